// File: doc/BRIEF.md
# Split TLB Address Translator

This block turns a 32-bit virtual address into a physical address using two direct-mapped translation tables, one for instruction fetches and one for data accesses, each holding 64 entries over 8 KiB pages. Each entry has two words. The match word holds the virtual page number and a valid flag. The translate word holds the physical page number and six permission bits: read, write and execute, for both user and supervisor mode. The same virtual-address index selects one entry from each table. When both entries point at the same physical page, their rights are merged into one permission set. When they differ, only the entry that the access type needs is kept.

The lookup is combinational. It returns the physical address, the granted rights and a hit flag in the same cycle as the request. The outcome of each request is registered into a 3-bit exception code. On a fault, the faulting virtual address is captured. Any armed load-linked reservation is also dropped. The reservation is kept by a two-state machine. `RSV_EMPTY` moves to `RSV_ARMED` when a reservation is set by a request that does not fault. `RSV_ARMED` stays in `RSV_ARMED` on a further successful set, which reloads the address. `RSV_ARMED` falls back to `RSV_EMPTY` on any faulting request. All other cases hold the current state.

Entries are loaded through a one-cycle write port that carries a word select, an index and data. When the translation unit is disabled, the address passes through unchanged with every right granted.

Top module: `xlat_split_tlb`

## Requirements
- R1: After reset, every entry of both tables is invalid. `exc_code` is 0, `fault_addr` is 0 and `rsv_valid` is 0. A translated load to any address then reports a data miss.
- R2: The entry index is `acc_vaddr[18:13]`. An entry is live only when match-word bit 0 is 1 and match-word bits [31:13] equal `acc_vaddr[31:13]`.
- R3: With `mmu_en`=0, `pa` equals `acc_vaddr`, `perm` is 3'b111 and `hit` is 1. A request then registers no exception.
- R4: Translate-word bits are: 1 user read, 2 user write, 3 user execute, 4 supervisor read, 5 supervisor write, 6 supervisor execute. Execute comes from the instruction entry and read/write from the data entry. `acc_super` picks the bit set, and a right needs a live entry. `perm` is {execute, write, read}.
- R5: `acc_kind` 2'b10 is a fetch needing execute, 2'b01 is a store needing write, and 2'b00 or 2'b11 is a load needing read. `hit` is 1 exactly when that right is granted.
- R6: A refused translated access has an exception code. If the entry supplying the needed right was live, the code is a page fault: 3 for a fetch, 4 otherwise. If not, the code is a miss: 1 for a fetch, 2 otherwise. Code 0 means no exception.
- R7: If the two translate words at the index hold different physical pages, a fetch ignores the data entry and any other access ignores the instruction entry. With equal pages, rights from both entries are reported together.
- R8: `pa` is the OR of the two kept translate words in bits [31:13], joined with `acc_vaddr[12:0]`.
- R9: `exc_code` shows, one cycle after a request, that request's code, and 0 after a cycle with `acc_req`=0.
- R10: On a faulting request, `fault_addr` takes `acc_vaddr` at the next edge. Otherwise it holds.
- R11: A non-faulting request with `rsv_set`=1 arms the reservation with `pa`. A faulting request clears it. Otherwise it holds.
- R12: `wr_sel` selects the word to write: 0 instruction match, 1 instruction translate, 2 data match, 3 data translate. The write takes effect at the clock edge, so a lookup in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable |
| acc_req | input | 1 | Access request present this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 00/11 load, 01 store, 10 fetch |
| acc_super | input | 1 | Supervisor privilege |
| rsv_set | input | 1 | Request is a load-linked that arms the reservation |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 2 | Word select for the write |
| wr_idx | input | 6 | Entry index for the write |
| wr_data | input | 32 | Word to write |
| pa | output | 32 | Physical address |
| perm | output | 3 | Granted rights {exec, write, read} |
| hit | output | 1 | Needed right granted |
| exc_code | output | 3 | Registered exception code of the previous cycle |
| fault_addr | output | 32 | Last faulting virtual address |
| rsv_valid | output | 1 | Reservation armed |
| rsv_addr | output | 32 | Reserved physical address |

## Verification
Several properties are checked on every cycle:
- the pass-through when translation is off;
- the page offset carried into `pa`;
- execute being granted whenever a fetch hits;
- the one-cycle link from a refused request to a nonzero registered code, and from a granted or absent request to code 0;
- capture of the fault address;
- loss of the reservation on a fault.

Other behaviour can only be shown by the bench's scenarios:
- the choice between miss and page fault;
- the instruction/data split when the physical pages differ;
- user versus supervisor rights;
- the old-contents view during a same-cycle write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SEL_IMATCH = 2'd0,
        SEL_ITRANS = 2'd1,
        SEL_DMATCH = 2'd2,
        SEL_DTRANS = 2'd3
    } wsel_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_e;

    // bit positions inside the entry words
    localparam int unsigned BIT_VALID = 0;
    localparam int unsigned BIT_UR    = 1;
    localparam int unsigned BIT_UW    = 2;
    localparam int unsigned BIT_UX    = 3;
    localparam int unsigned BIT_SR    = 4;
    localparam int unsigned BIT_SW    = 5;
    localparam int unsigned BIT_SX    = 6;

    // bit positions of the granted-rights vector
    localparam int unsigned PERM_R = 0;
    localparam int unsigned PERM_W = 1;
    localparam int unsigned PERM_X = 2;

endpackage

// File: rtl/xlat_tlb_bank.sv
// One direct-mapped table: a match word and a translate word per entry.
// Writes land on the clock edge; reads are combinational (old contents).
module xlat_tlb_bank #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_match,
    input  logic              we_trans,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_match,
    output logic [WORD_W-1:0] rd_trans
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] match_q [DEPTH];
    logic [WORD_W-1:0] trans_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                match_q[i] <= '0;
                trans_q[i] <= '0;
            end
        end else begin
            if (we_match) begin
                match_q[wr_idx] <= wr_data;
            end
            if (we_trans) begin
                trans_q[wr_idx] <= wr_data;
            end
        end
    end

    assign rd_match = match_q[rd_idx];
    assign rd_trans = trans_q[rd_idx];

endmodule

// File: rtl/xlat_lookup.sv
// Combinational translation and permission evaluation for one index.
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 13
) (
    input  logic [ADDR_W-1:0] imr,
    input  logic [ADDR_W-1:0] itr,
    input  logic [ADDR_W-1:0] dmr,
    input  logic [ADDR_W-1:0] dtr,
    input  logic [ADDR_W-1:0] va,
    input  logic [1:0]        kind,
    input  logic              sup,
    input  logic              mmu_en,
    output logic [ADDR_W-1:0] pa,
    output logic [2:0]        perm,
    output logic              hit,
    output logic [2:0]        code
);
    localparam int unsigned VPN_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0] imr_e, itr_e, dmr_e, dtr_e;
    logic              is_fetch, is_store;
    logic              i_live, d_live;
    logic              right_x, right_r, right_w;
    logic [VPN_W-1:0]  phys_page;
    logic              granted, need_live;
    logic [2:0]        code_tr;

    assign is_fetch = (kind == ACC_FETCH);
    assign is_store = (kind == ACC_STORE);

    // keep only the entry the access needs when the physical pages differ
    always_comb begin
        imr_e = imr;
        itr_e = itr;
        dmr_e = dmr;
        dtr_e = dtr;
        if (itr[ADDR_W-1:PAGE_BITS] != dtr[ADDR_W-1:PAGE_BITS]) begin
            if (is_fetch) begin
                dmr_e = '0;
                dtr_e = '0;
            end else begin
                imr_e = '0;
                itr_e = '0;
            end
        end
    end

    assign i_live = imr_e[BIT_VALID] && (imr_e[ADDR_W-1:PAGE_BITS] == va[ADDR_W-1:PAGE_BITS]);
    assign d_live = dmr_e[BIT_VALID] && (dmr_e[ADDR_W-1:PAGE_BITS] == va[ADDR_W-1:PAGE_BITS]);

    assign right_x = i_live && (sup ? itr_e[BIT_SX] : itr_e[BIT_UX]);
    assign right_r = d_live && (sup ? dtr_e[BIT_SR] : dtr_e[BIT_UR]);
    assign right_w = d_live && (sup ? dtr_e[BIT_SW] : dtr_e[BIT_UW]);

    assign phys_page = itr_e[ADDR_W-1:PAGE_BITS] | dtr_e[ADDR_W-1:PAGE_BITS];

    always_comb begin
        if (is_fetch) begin
            granted   = right_x;
            need_live = i_live;
        end else if (is_store) begin
            granted   = right_w;
            need_live = d_live;
        end else begin
            granted   = right_r;
            need_live = d_live;
        end
    end

    always_comb begin
        if (granted) begin
            code_tr = EXC_NONE;
        end else if (need_live) begin
            code_tr = is_fetch ? EXC_IPF : EXC_DPF;
        end else begin
            code_tr = is_fetch ? EXC_IMISS : EXC_DMISS;
        end
    end

    always_comb begin
        if (mmu_en) begin
            pa           = {phys_page, va[PAGE_BITS-1:0]};
            perm         = '0;
            perm[PERM_R] = right_r;
            perm[PERM_W] = right_w;
            perm[PERM_X] = right_x;
            hit          = granted;
            code         = code_tr;
        end else begin
            pa   = va;
            perm = 3'b111;
            hit  = 1'b1;
            code = EXC_NONE;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{imr_e[PAGE_BITS-1:0], dmr_e[PAGE_BITS-1:0],
                           itr_e[PAGE_BITS-1:0], dtr_e[PAGE_BITS-1:0]};

endmodule

// File: rtl/xlat_fault_ctl.sv
// Registers the exception code, captures the faulting address and runs
// the load-linked reservation state machine.
module xlat_fault_ctl
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              rsv_set,
    input  logic [2:0]        lk_code,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] paddr,
    output logic [2:0]        exc_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              rsv_valid,
    output logic [ADDR_W-1:0] rsv_addr
);
    rsv_e              state_q, state_d;
    logic              fault, arm;
    logic [2:0]        exc_q;
    logic [ADDR_W-1:0] fault_q, rsv_q;

    assign fault = acc_req && (lk_code != EXC_NONE);
    assign arm   = acc_req && rsv_set && !fault;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: if (arm)   state_d = RSV_ARMED;
            RSV_ARMED: if (fault) state_d = RSV_EMPTY;
            default:              state_d = RSV_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q   <= EXC_NONE;
            fault_q <= '0;
            rsv_q   <= '0;
        end else begin
            exc_q <= acc_req ? lk_code : EXC_NONE;
            if (fault) begin
                fault_q <= vaddr;
            end
            if (arm) begin
                rsv_q <= paddr;
            end
        end
    end

    assign exc_code   = exc_q;
    assign fault_addr = fault_q;
    assign rsv_valid  = (state_q == RSV_ARMED);
    assign rsv_addr   = rsv_q;

endmodule

// File: rtl/xlat_split_tlb.sv
module xlat_split_tlb
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PAGE_BITS   = 13,
    parameter int unsigned TLB_ENTRIES = 64,
    localparam int unsigned IDX_W      = $clog2(TLB_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_en,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_vaddr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_super,
    input  logic              rsv_set,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] pa,
    output logic [2:0]        perm,
    output logic              hit,
    output logic [2:0]        exc_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              rsv_valid,
    output logic [ADDR_W-1:0] rsv_addr
);
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] bank_mr [2];
    logic [ADDR_W-1:0] bank_tr [2];
    logic [2:0]        lk_code;

    assign rd_idx = acc_vaddr[PAGE_BITS+IDX_W-1:PAGE_BITS];

    // bank 0 serves fetches, bank 1 serves data accesses
    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam wsel_e MSEL = (b == 0) ? SEL_IMATCH : SEL_DMATCH;
        localparam wsel_e TSEL = (b == 0) ? SEL_ITRANS : SEL_DTRANS;
        xlat_tlb_bank #(
            .WORD_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_match (wr_en && (wr_sel == MSEL)),
            .we_trans (wr_en && (wr_sel == TSEL)),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .rd_idx   (rd_idx),
            .rd_match (bank_mr[b]),
            .rd_trans (bank_tr[b])
        );
    end

    xlat_lookup #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_lookup (
        .imr    (bank_mr[0]),
        .itr    (bank_tr[0]),
        .dmr    (bank_mr[1]),
        .dtr    (bank_tr[1]),
        .va     (acc_vaddr),
        .kind   (acc_kind),
        .sup    (acc_super),
        .mmu_en (mmu_en),
        .pa     (pa),
        .perm   (perm),
        .hit    (hit),
        .code   (lk_code)
    );

    xlat_fault_ctl #(
        .ADDR_W (ADDR_W)
    ) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .rsv_set    (rsv_set),
        .lk_code    (lk_code),
        .vaddr      (acc_vaddr),
        .paddr      (pa),
        .exc_code   (exc_code),
        .fault_addr (fault_addr),
        .rsv_valid  (rsv_valid),
        .rsv_addr   (rsv_addr)
    );

endmodule

// File: rtl/xlat_split_tlb_chk.sv
module xlat_split_tlb_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mmu_en,
    input logic              acc_req,
    input logic [ADDR_W-1:0] acc_vaddr,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] pa,
    input logic [2:0]        perm,
    input logic              hit,
    input logic [2:0]        exc_code,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              rsv_valid
);
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_en |-> (hit && perm == 3'b111 && pa == acc_vaddr));

    a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pa[PAGE_BITS-1:0] == acc_vaddr[PAGE_BITS-1:0]);

    a_r5_fetch_hit_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_en && acc_kind == 2'b10 && hit) |-> perm[2]);

    a_r9_refused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !hit) |=> (exc_code != 3'd0));

    a_r9_granted_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && hit) |=> (exc_code == 3'd0));

    a_r9_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (exc_code == 3'd0));

    a_r10_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !hit) |=> (fault_addr == $past(acc_vaddr)));

    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !hit) |=> $stable(fault_addr));

    a_r11_fault_drops_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !hit) |=> !rsv_valid);

endmodule

bind xlat_split_tlb xlat_split_tlb_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mmu_en     (mmu_en),
    .acc_req    (acc_req),
    .acc_vaddr  (acc_vaddr),
    .acc_kind   (acc_kind),
    .pa         (pa),
    .perm       (perm),
    .hit        (hit),
    .exc_code   (exc_code),
    .fault_addr (fault_addr),
    .rsv_valid  (rsv_valid)
);

// File: tb/test_xlat_split_tlb.sv
module test_xlat_split_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_en = 1'b0;
    logic        acc_req = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_super = 1'b0;
    logic        rsv_set = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] pa, fault_addr, rsv_addr;
    logic [2:0]  perm, exc_code;
    logic        hit, rsv_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    xlat_split_tlb i_xlat_split_tlb (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .acc_req(acc_req),
        .acc_vaddr(acc_vaddr), .acc_kind(acc_kind), .acc_super(acc_super),
        .rsv_set(rsv_set), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .pa(pa), .perm(perm), .hit(hit),
        .exc_code(exc_code), .fault_addr(fault_addr), .rsv_valid(rsv_valid),
        .rsv_addr(rsv_addr)
    );

    localparam logic [1:0] K_LOAD = 2'b00, K_STORE = 2'b01, K_FETCH = 2'b10, K_LOAD2 = 2'b11;
    localparam logic [2:0] C_NONE = 3'd0, C_IMISS = 3'd1, C_DMISS = 3'd2, C_IPF = 3'd3, C_DPF = 3'd4;
    localparam logic [31:0] UR = 32'h02, UW = 32'h04, UX = 32'h08, SR = 32'h10, SW = 32'h20, SX = 32'h40;

    localparam logic [31:0] VA_A  = 32'h1234_2ABC;
    localparam logic [31:0] VA_A2 = VA_A ^ 32'h4000_0000;
    localparam logic [31:0] PG_A  = 32'h8000_4000;
    localparam logic [31:0] VA_B  = 32'h0000_A123;
    localparam logic [31:0] PG_BI = 32'h0040_0000;
    localparam logic [31:0] PG_BD = 32'h0060_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] match_word(input logic [31:0] va);
        return {va[31:13], 13'd0} | 32'd1;
    endfunction

    // scoreboard monitor: one expected code per request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {29'd0, exc_code}, {29'd0, e});
            end
        end
    end

    task automatic wr_word(input logic [1:0] sel, input logic [31:0] va_or_idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = va_or_idx[18:13]; wr_data = data;
        @(posedge clk);
        #3 wr_en = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] va, input logic [1:0] kind,
                          input logic sup, input logic rs, input logic exp_hit,
                          input logic [31:0] exp_pa, input logic [2:0] exp_perm,
                          input logic [2:0] exp_code, input bit cmp_pa);
        @(negedge clk);
        acc_req = 1'b1; acc_vaddr = va; acc_kind = kind; acc_super = sup; rsv_set = rs;
        #1;
        chk({req, " hit"}, {31'd0, hit}, {31'd0, exp_hit});
        if (cmp_pa) begin
            chk({req, " pa"}, pa, exp_pa);
            chk({req, " perm"}, {29'd0, perm}, {29'd0, exp_perm});
        end
        exp_q.push_back(exp_code);
        tag_q.push_back({req, " exc_code"});
        @(posedge clk);
        #3 acc_req = 1'b0; rsv_set = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 exc after reset", {29'd0, exc_code}, 32'd0);
        chk("R1 rsv after reset", {31'd0, rsv_valid}, 32'd0);
        chk("R1 fault_addr after reset", fault_addr, 32'd0);
        mmu_en = 1'b1;
        access("R1 empty table load", 32'h0000_0100, K_LOAD, 1'b0, 1'b0, 1'b0, 32'd0, 3'd0, C_DMISS, 1'b0);

        // R3 disabled translation
        mmu_en = 1'b0;
        access("R3 passthrough", 32'hDEAD_BEEF, K_STORE, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 3'b111, C_NONE, 1'b1);
        mmu_en = 1'b1;

        // R12 load entries through the select encoding
        wr_word(2'd0, VA_A, match_word(VA_A));
        wr_word(2'd1, VA_A, PG_A | SX);
        wr_word(2'd2, VA_A, match_word(VA_A));
        wr_word(2'd3, VA_A, PG_A | UR | UW | SR);

        // R2 R4 R5 R8 shared page, user load
        access("R4 R8 user load", VA_A, K_LOAD, 1'b0, 1'b0, 1'b1, 32'h8000_4ABC, 3'b011, C_NONE, 1'b1);
        access("R5 user load alt code", VA_A, K_LOAD2, 1'b0, 1'b0, 1'b1, 32'h8000_4ABC, 3'b011, C_NONE, 1'b1);
        access("R5 user store", VA_A, K_STORE, 1'b0, 1'b0, 1'b1, 32'h8000_4ABC, 3'b011, C_NONE, 1'b1);
        // R6 page fault on fetch without user execute
        access("R6 user fetch ipf", VA_A, K_FETCH, 1'b0, 1'b0, 1'b0, 32'd0, 3'd0, C_IPF, 1'b0);
        // R7 merged rights under supervisor
        access("R7 R4 super fetch", VA_A, K_FETCH, 1'b1, 1'b0, 1'b1, 32'h8000_4ABC, 3'b101, C_NONE, 1'b1);
        access("R6 super store dpf", VA_A, K_STORE, 1'b1, 1'b0, 1'b0, 32'd0, 3'd0, C_DPF, 1'b0);
        chk("R10 fault addr captured", fault_addr, VA_A);

        // R9 idle cycle clears code, R10 holds address
        @(posedge clk);
        #3;
        chk("R9 idle code", {29'd0, exc_code}, 32'd0);
        chk("R10 fault addr held", fault_addr, VA_A);

        // R11 reservation
        access("R11 arm load", VA_A, K_LOAD, 1'b0, 1'b1, 1'b1, 32'h8000_4ABC, 3'b011, C_NONE, 1'b1);
        chk("R11 rsv armed", {31'd0, rsv_valid}, 32'd1);
        chk("R11 rsv addr", rsv_addr, 32'h8000_4ABC);
        access("R11 plain hit", VA_A, K_LOAD, 1'b0, 1'b0, 1'b1, 32'h8000_4ABC, 3'b011, C_NONE, 1'b1);
        chk("R11 rsv held", {31'd0, rsv_valid}, 32'd1);

        // R2 tag mismatch on same index
        access("R2 R6 tag miss fetch", VA_A2, K_FETCH, 1'b0, 1'b0, 1'b0, 32'd0, 3'd0, C_IMISS, 1'b0);
        chk("R11 rsv cleared by fault", {31'd0, rsv_valid}, 32'd0);
        chk("R10 fault addr second", fault_addr, VA_A2);
        access("R2 R6 tag miss load", VA_A2, K_LOAD, 1'b1, 1'b0, 1'b0, 32'd0, 3'd0, C_DMISS, 1'b0);

        // R7 split pages
        wr_word(2'd0, VA_B, match_word(VA_B));
        wr_word(2'd1, VA_B, PG_BI | UX);
        wr_word(2'd2, VA_B, match_word(VA_B));
        wr_word(2'd3, VA_B, PG_BD | UR);
        access("R7 split fetch", VA_B, K_FETCH, 1'b0, 1'b0, 1'b1, 32'h0040_0123, 3'b100, C_NONE, 1'b1);
        access("R7 split load", VA_B, K_LOAD, 1'b0, 1'b0, 1'b1, 32'h0060_0123, 3'b001, C_NONE, 1'b1);
        access("R7 R6 split store dpf", VA_B, K_STORE, 1'b0, 1'b0, 1'b0, 32'd0, 3'd0, C_DPF, 1'b0);

        // R12 same-cycle write sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_idx = VA_B[18:13]; wr_data = 32'd0;
        acc_req = 1'b1; acc_vaddr = VA_B; acc_kind = K_LOAD; acc_super = 1'b0;
        #1;
        chk("R12 old contents hit", {31'd0, hit}, 32'd1);
        exp_q.push_back(C_NONE);
        tag_q.push_back("R12 old contents exc_code");
        @(posedge clk);
        #3 wr_en = 1'b0; acc_req = 1'b0;
        access("R12 after write miss", VA_B, K_LOAD, 1'b0, 1'b0, 1'b0, 32'd0, 3'd0, C_DMISS, 1'b0);

        // R3 disabled translation on an invalid entry raises nothing
        mmu_en = 1'b0;
        access("R3 passthrough on miss", VA_B, K_LOAD, 1'b0, 1'b0, 1'b1, VA_B, 3'b111, C_NONE, 1'b1);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule